// File: doc/BRIEF.md
# Three-Slice Cascaded 48-bit ALU

This block builds a 48-bit arithmetic logic unit from three identical 16-bit slices. Each slice holds two operand registers and a result register, and each of these stages can be bypassed. An operand selector picks the two ALU inputs from the A operand, the B operand, the fed-back result register, or zero. A three-bit function code then chooses one of eight operations. All slices share the function code, the operand select, the clock, the three register loads and the two bypass controls, so the three slices behave as one wide datapath.

The slices are joined by one of two carry schemes, chosen at build time. In ripple mode, each slice's carry-out feeds the carry-in of the slice above it. In lookahead mode, a generator turns each slice's active-low propagate and generate outputs into the carry-ins of the upper slices in one flat level of logic. In both modes the system carry-in enters the lowest slice, and in lookahead mode it also enters the generator.

The system carry-out, overflow, propagate and generate flags come from the top slice. The zero flag is the AND of the three slice zero flags.

Top module: `cascade_alu48`

## Requirements
- R1: Operand select codes give (R, S) as follows: 0 gives (A, result register), 1 gives (A, 0), 2 gives (0, B), 3 gives (A, B).
- R2: The function code gives f as follows: 0 clears f to 0, 1 gives S + ~R + cin, 2 gives R + ~S + cin, 3 gives R + S + cin, 4 gives R xor S, 5 gives R or S, 6 gives R and S, 7 sets every bit to 1.
- R3: In ripple mode (LOOKAHEAD=0), arithmetic is exact over all 48 bits, with carries crossing both slice boundaries.
- R4: In lookahead mode (LOOKAHEAD=1), the carry into slice k+1 is G_k or (P_k and the carry into slice k), written in flat two-level form. The results and flags are identical to ripple mode for every input.
- R5: For arithmetic codes (1 to 3), cout is the carry out of bit 47 and ovf is the two's-complement overflow of the 48-bit add. For all other codes both flags are 0.
- R6: prop_n and gen_n are the active-low propagate and generate of the top slice, computed over bits 47:32 of the adder inputs. For non-arithmetic codes both are 1, and an active generate implies cout.
- R7: zero is 1 exactly when all 48 bits of the ALU result are 0.
- R8: a_ld and b_ld load the operand registers on a rising clock edge. When op_thru is 1, the ALU reads a_in and b_in directly.
- R9: When f_ld is 1, the result register loads the ALU result on a rising clock edge, and otherwise it holds its value. f_out shows the ALU result when f_thru is 1 and the result register when f_thru is 0. The operand feedback path always reads the result register.
- R10: A synchronous active-high rst clears the operand registers and the result register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 48 | A operand |
| b_in | input | 48 | B operand |
| cin | input | 1 | System carry-in |
| func | input | 3 | Function code |
| opsel | input | 2 | Operand select code |
| a_ld | input | 1 | Load enable for the A register |
| b_ld | input | 1 | Load enable for the B register |
| f_ld | input | 1 | Load enable for the result register |
| op_thru | input | 1 | Bypass both operand registers |
| f_thru | input | 1 | Bypass the result register at the output |
| f_out | output | 48 | Result |
| cout | output | 1 | Carry-out of the top slice |
| ovf | output | 1 | Signed overflow of the top slice |
| prop_n | output | 1 | Active-low propagate of the top slice |
| gen_n | output | 1 | Active-low generate of the top slice |
| zero | output | 1 | Whole-result zero flag |

## Verification
Directed patterns exercise the carry paths:
- A low part of all ones plus one checks that a carry crosses both slice boundaries.
- All ones plus one checks the wrap to zero with a carry-out.
- The largest positive number plus one checks overflow.
- A top slice made entirely of propagating bits checks that prop_n is driven from the upper 16 bits only.

Long random runs then vary operands, carry-in, every function and select code, the loads, the bypasses and occasional resets. Each cycle, both a ripple build and a lookahead build are compared with a behavioural 48-bit model, and with each other. Any mismatch between the two builds can only come from the inter-slice carry logic. Select code 0 with the result register loaded repeatedly makes an accumulator, which tests the feedback path through the register across many cycles.

// File: rtl/wide_alu_pkg.sv
package wide_alu_pkg;
  typedef enum logic [2:0] {
    FN_CLEAR = 3'd0,
    FN_S_MINUS_R = 3'd1,
    FN_R_MINUS_S = 3'd2,
    FN_ADD = 3'd3,
    FN_XOR = 3'd4,
    FN_OR = 3'd5,
    FN_AND = 3'd6,
    FN_ONES = 3'd7
  } alu_fn_e;

  typedef enum logic [1:0] {
    SEL_A_FB = 2'd0,
    SEL_A_ZERO = 2'd1,
    SEL_ZERO_B = 2'd2,
    SEL_A_B = 2'd3
  } op_sel_e;

  function automatic logic is_arith(input logic [2:0] fn);
    return (fn == FN_S_MINUS_R) || (fn == FN_R_MINUS_S) || (fn == FN_ADD);
  endfunction
endpackage

// File: rtl/alu_slice_core.sv
module alu_slice_core #(
  parameter int W = 16
) (
  input  logic [W-1:0] r_op,
  input  logic [W-1:0] s_op,
  input  logic [2:0]   func,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         ovf,
  output logic         prop,
  output logic         gen
);
  import wide_alu_pkg::*;

  logic [W-1:0] x, y;
  logic [W:0]   sum, gsum;

  always_comb begin
    x = r_op;
    y = s_op;
    case (func)
      FN_S_MINUS_R: x = ~r_op;
      FN_R_MINUS_S: y = ~s_op;
      default: ;
    endcase
    sum  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    gsum = {1'b0, x} + {1'b0, y};
    res  = sum[W-1:0];
    cout = 1'b0;
    ovf  = 1'b0;
    prop = 1'b0;
    gen  = 1'b0;
    if (is_arith(func)) begin
      cout = sum[W];
      ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
      prop = &(x ^ y);
      gen  = gsum[W];
    end else begin
      case (func)
        FN_CLEAR: res = '0;
        FN_XOR:   res = r_op ^ s_op;
        FN_OR:    res = r_op | s_op;
        FN_AND:   res = r_op & s_op;
        default:  res = '1;
      endcase
    end
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         cin,
  input  logic [2:0]   func,
  input  logic [1:0]   opsel,
  input  logic         a_ld,
  input  logic         b_ld,
  input  logic         f_ld,
  input  logic         op_thru,
  input  logic         f_thru,
  output logic [W-1:0] f_out,
  output logic         cout,
  output logic         ovf,
  output logic         prop_n,
  output logic         gen_n,
  output logic         zero
);
  import wide_alu_pkg::*;

  logic [W-1:0] a_q, b_q, f_q;
  logic [W-1:0] a_op, b_op, r_op, s_op, res;
  logic         prop, gen;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
      f_q <= '0;
    end else begin
      if (a_ld) a_q <= a_in;
      if (b_ld) b_q <= b_in;
      if (f_ld) f_q <= res;
    end
  end

  assign a_op = op_thru ? a_in : a_q;
  assign b_op = op_thru ? b_in : b_q;

  always_comb begin
    case (opsel)
      SEL_A_FB:   begin r_op = a_op; s_op = f_q;  end
      SEL_A_ZERO: begin r_op = a_op; s_op = '0;   end
      SEL_ZERO_B: begin r_op = '0;   s_op = b_op; end
      default:    begin r_op = a_op; s_op = b_op; end
    endcase
  end

  alu_slice_core #(.W(W)) core_i (
    .r_op(r_op), .s_op(s_op), .func(func), .cin(cin),
    .res(res), .cout(cout), .ovf(ovf), .prop(prop), .gen(gen)
  );

  assign prop_n = ~prop;
  assign gen_n  = ~gen;
  assign zero   = ~|res;
  assign f_out  = f_thru ? res : f_q;
endmodule

// File: rtl/slice_lookahead.sv
module slice_lookahead #(
  parameter int N = 3
) (
  input  logic [N-1:0] prop_n,
  input  logic [N-1:0] gen_n,
  input  logic         cin,
  output logic [N-1:0] carry
);
  logic [N-1:0] p, g;
  logic         unused_top;

  assign p = ~prop_n;
  assign g = ~gen_n;
  assign unused_top = p[N-1] ^ g[N-1];

  always_comb begin
    carry[0] = cin;
    for (int k = 1; k < N; k++) begin
      logic acc, term;
      acc = cin;
      for (int m = 0; m < k; m++) acc = acc & p[m];
      for (int j = 0; j < k; j++) begin
        term = g[j];
        for (int m = j + 1; m < k; m++) term = term & p[m];
        acc = acc | term;
      end
      carry[k] = acc;
    end
  end
endmodule

// File: rtl/cascade_alu48.sv
module cascade_alu48 #(
  parameter int SLICE_W   = 16,
  parameter int N_SLICES  = 3,
  parameter bit LOOKAHEAD = 1'b0,
  localparam int W = SLICE_W * N_SLICES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         cin,
  input  logic [2:0]   func,
  input  logic [1:0]   opsel,
  input  logic         a_ld,
  input  logic         b_ld,
  input  logic         f_ld,
  input  logic         op_thru,
  input  logic         f_thru,
  output logic [W-1:0] f_out,
  output logic         cout,
  output logic         ovf,
  output logic         prop_n,
  output logic         gen_n,
  output logic         zero
);
  logic [N_SLICES-1:0] s_cin, s_cout, s_ovf, s_prop_n, s_gen_n, s_zero;
  logic                unused_lower;

  generate
    if (LOOKAHEAD) begin : g_cla
      slice_lookahead #(.N(N_SLICES)) cla_i (
        .prop_n(s_prop_n), .gen_n(s_gen_n), .cin(cin), .carry(s_cin)
      );
    end else begin : g_ripple
      assign s_cin[0] = cin;
      for (genvar i = 1; i < N_SLICES; i++) begin : g_link
        assign s_cin[i] = s_cout[i-1];
      end
    end

    for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
      alu_slice #(.W(SLICE_W)) slice_i (
        .clk(clk), .rst(rst),
        .a_in(a_in[i*SLICE_W +: SLICE_W]),
        .b_in(b_in[i*SLICE_W +: SLICE_W]),
        .cin(s_cin[i]), .func(func), .opsel(opsel),
        .a_ld(a_ld), .b_ld(b_ld), .f_ld(f_ld),
        .op_thru(op_thru), .f_thru(f_thru),
        .f_out(f_out[i*SLICE_W +: SLICE_W]),
        .cout(s_cout[i]), .ovf(s_ovf[i]),
        .prop_n(s_prop_n[i]), .gen_n(s_gen_n[i]), .zero(s_zero[i])
      );
    end
  endgenerate

  assign unused_lower = ^{s_cout, s_ovf, s_prop_n, s_gen_n};

  assign cout   = s_cout[N_SLICES-1];
  assign ovf    = s_ovf[N_SLICES-1];
  assign prop_n = s_prop_n[N_SLICES-1];
  assign gen_n  = s_gen_n[N_SLICES-1];
  assign zero   = &s_zero;
endmodule

// File: rtl/cascade_alu48_chk.sv
module cascade_alu48_chk #(
  parameter int DATA_W = 48
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] a_in,
  input logic              cin,
  input logic [2:0]        func,
  input logic [1:0]        opsel,
  input logic              op_thru,
  input logic              f_ld,
  input logic              f_thru,
  input logic [DATA_W-1:0] f_out,
  input logic              cout,
  input logic              ovf,
  input logic              prop_n,
  input logic              gen_n,
  input logic              zero
);
  logic logic_fn;
  assign logic_fn = !((func == 3'd1) || (func == 3'd2) || (func == 3'd3));

  // R5: non-arithmetic codes raise neither carry nor overflow
  a_r5_logic_no_carry: assert property (@(posedge clk) disable iff (rst)
    logic_fn |-> (!cout && !ovf));

  // R6: propagate and generate stay inactive for non-arithmetic codes
  a_r6_pg_idle: assert property (@(posedge clk) disable iff (rst)
    logic_fn |-> (prop_n && gen_n));

  // R6: an active generate forces a carry-out
  a_r6_gen_gives_cout: assert property (@(posedge clk) disable iff (rst)
    !gen_n |-> cout);

  // R7: a visible non-zero result never reports zero
  a_r7_zero_matches: assert property (@(posedge clk) disable iff (rst)
    (f_thru && (f_out != '0)) |-> !zero);

  // R8: full bypass of A plus zero reproduces the input
  a_r8_bypass_pass: assert property (@(posedge clk) disable iff (rst)
    (op_thru && f_thru && opsel == 2'd1 && func == 3'd3 && !cin) |-> (f_out == a_in));

  // R9: result register holds without a load
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!f_ld && !f_thru) |=> (f_thru || f_out == $past(f_out)));
endmodule

bind cascade_alu48 cascade_alu48_chk #(.DATA_W(SLICE_W * N_SLICES)) chk_i (
  .clk(clk), .rst(rst), .a_in(a_in), .cin(cin), .func(func), .opsel(opsel),
  .op_thru(op_thru), .f_ld(f_ld), .f_thru(f_thru), .f_out(f_out),
  .cout(cout), .ovf(ovf), .prop_n(prop_n), .gen_n(gen_n), .zero(zero)
);

// File: tb/cascade_alu48_tb_top.sv
module cascade_alu48_tb_top;
  localparam int SW = 16;
  localparam int NS = 3;
  localparam int W  = SW * NS;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] a_in, b_in;
  logic cin, a_ld, b_ld, f_ld, op_thru, f_thru;
  logic [2:0] func;
  logic [1:0] opsel;

  logic [W-1:0] f_rp, f_la;
  logic co_rp, ov_rp, pn_rp, gn_rp, z_rp;
  logic co_la, ov_la, pn_la, gn_la, z_la;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  // model state
  logic [W-1:0] m_a, m_b, m_f;
  logic [W-1:0] e_res, e_out;
  logic e_co, e_ov, e_pn, e_gn, e_z;

  always #4 clk = ~clk;

  cascade_alu48 #(.SLICE_W(SW), .N_SLICES(NS), .LOOKAHEAD(1'b0)) dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .cin(cin), .func(func),
    .opsel(opsel), .a_ld(a_ld), .b_ld(b_ld), .f_ld(f_ld), .op_thru(op_thru),
    .f_thru(f_thru), .f_out(f_rp), .cout(co_rp), .ovf(ov_rp),
    .prop_n(pn_rp), .gen_n(gn_rp), .zero(z_rp));

  cascade_alu48 #(.SLICE_W(SW), .N_SLICES(NS), .LOOKAHEAD(1'b1)) dut_la_i (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .cin(cin), .func(func),
    .opsel(opsel), .a_ld(a_ld), .b_ld(b_ld), .f_ld(f_ld), .op_thru(op_thru),
    .f_thru(f_thru), .f_out(f_la), .cout(co_la), .ovf(ov_la),
    .prop_n(pn_la), .gen_n(gn_la), .zero(z_la));

  task automatic chk(input string what, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic model_eval();
    logic [W-1:0] ao, bo, r, s, x, y;
    logic [W:0] sum;
    logic [SW:0] gt;
    ao = op_thru ? a_in : m_a;
    bo = op_thru ? b_in : m_b;
    case (opsel)  // R1 mapping
      2'd0: begin r = ao; s = m_f; end
      2'd1: begin r = ao; s = '0; end
      2'd2: begin r = '0; s = bo; end
      default: begin r = ao; s = bo; end
    endcase
    x = (func == 3'd1) ? ~r : r;
    y = (func == 3'd2) ? ~s : s;
    sum = {1'b0, x} + {1'b0, y} + W'(cin);
    gt = {1'b0, x[W-1 -: SW]} + {1'b0, y[W-1 -: SW]};
    e_co = 0; e_ov = 0; e_pn = 1; e_gn = 1;
    case (func)
      3'd0: e_res = '0;
      3'd4: e_res = r ^ s;
      3'd5: e_res = r | s;
      3'd6: e_res = r & s;
      3'd7: e_res = '1;
      default: begin
        e_res = sum[W-1:0];
        e_co = sum[W];
        e_ov = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
        e_pn = ~&(x[W-1 -: SW] ^ y[W-1 -: SW]);
        e_gn = ~gt[SW];
      end
    endcase
    e_z = (e_res == '0);
    e_out = f_thru ? e_res : m_f;
  endtask

  task automatic step(input string tag);
    #1;
    model_eval();
    chk({tag, " R2/R9 f_out ripple"}, f_rp, e_out);
    chk({tag, " R4 f_out lookahead"}, f_la, e_out);
    chk({tag, " R5 cout"}, W'(co_rp), W'(e_co));
    chk({tag, " R5 ovf"}, W'(ov_rp), W'(e_ov));
    chk({tag, " R6 prop_n"}, W'(pn_rp), W'(e_pn));
    chk({tag, " R6 gen_n"}, W'(gn_rp), W'(e_gn));
    chk({tag, " R7 zero"}, W'(z_rp), W'(e_z));
    chk({tag, " R4 flags match"}, W'({co_la, ov_la, pn_la, gn_la, z_la}),
        W'({co_rp, ov_rp, pn_rp, gn_rp, z_rp}));
    @(posedge clk);
    if (rst) begin
      m_a = '0; m_b = '0; m_f = '0;  // R10
    end else begin
      if (a_ld) m_a = a_in;
      if (b_ld) m_b = b_in;
      if (f_ld) m_f = e_res;
    end
    @(negedge clk);
  endtask

  task automatic setin(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                       input logic [2:0] fn, input logic [1:0] sel);
    a_in = a; b_in = b; cin = c; func = fn; opsel = sel;
  endtask

  function automatic logic [W-1:0] rnd48();
    return {$urandom(), $urandom()} >> (64 - W);
  endfunction

  initial begin
    rst = 1; a_in = '0; b_in = '0; cin = 0; func = 3'd3; opsel = 2'd3;
    a_ld = 1; b_ld = 1; f_ld = 1; op_thru = 0; f_thru = 0;
    m_a = 'x; m_b = 'x; m_f = 'x;
    @(negedge clk);
    @(negedge clk);
    m_a = '0; m_b = '0; m_f = '0;
    @(negedge clk);
    // R10: reset state seen through the registered path
    a_ld = 0; b_ld = 0; f_ld = 0;
    step("R10 reset");
    rst = 0;
    op_thru = 1; f_thru = 1; a_ld = 1; b_ld = 1; f_ld = 1;
    // R3: carry crosses both slice boundaries
    setin(48'h0000_FFFF_FFFF, 48'h1, 0, 3'd3, 2'd3); step("R3 cross");
    // R5/R7: wrap to zero with carry
    setin('1, 48'h1, 0, 3'd3, 2'd3); step("R5 wrap");
    setin('1, '0, 1, 3'd3, 2'd3); step("R5 cin wrap");
    // R5: signed overflow
    setin(48'h7FFF_FFFF_FFFF, 48'h1, 0, 3'd3, 2'd3); step("R5 ovf");
    // R6: top slice all propagate
    setin(48'hFFFF_0000_0000, 48'h0000_1234_0000, 0, 3'd3, 2'd3); step("R6 prop");
    // R2: subtraction orders
    setin(48'h5, 48'h9, 1, 3'd1, 2'd3); step("R2 s-r");
    setin(48'h5, 48'h9, 1, 3'd2, 2'd3); step("R2 r-s");
    // R8: registered operands held while loads off
    op_thru = 0; setin(48'h1234_5678_9ABC, 48'h1, 0, 3'd3, 2'd3); step("R8 load");
    a_ld = 0; b_ld = 0; setin('1, '1, 0, 3'd3, 2'd3); step("R8 hold");
    // R9: accumulator via feedback, output registered
    f_thru = 0; a_ld = 1;
    for (int i = 0; i < 8; i++) begin
      setin(48'h0000_8000_0001, '0, 0, 3'd3, 2'd0); step("R9 accum");
    end
    // R1/R4: random sweep over every code
    for (int i = 0; i < 6000; i++) begin
      rst = ($urandom_range(0, 199) == 0);
      a_ld = $urandom_range(0, 1); b_ld = $urandom_range(0, 1);
      f_ld = $urandom_range(0, 3) != 0;
      op_thru = $urandom_range(0, 1); f_thru = $urandom_range(0, 1);
      case ($urandom_range(0, 3))
        0: a_in = '1;
        1: a_in = rnd48() | 48'h0000_FFFF_FFFF;
        default: a_in = rnd48();
      endcase
      b_in = ($urandom_range(0, 3) == 0) ? ~a_in : rnd48();
      cin = $urandom_range(0, 1);
      func = 3'($urandom_range(0, 7));
      opsel = 2'($urandom_range(0, 3));
      step("R1 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule